// File: doc/BRIEF.md
# Hybrid Snoop Miss Filter

This block sits in front of one node's L2 tag array, on the path of snoops arriving from the shared bus. For every snoop address it decides whether the tag lookup can be skipped because the block is certainly not held locally (drop), or whether the snoop must go on to the tags because the block may be held (forward). Dropping a snoop that would have missed saves a tag access. Dropping a snoop that would have hit is never allowed.

Two imprecise structures are consulted side by side. The first is a counting Bloom filter. The local cache increments it when it fills a block and decrements it when it evicts one, so it always covers a superset of the resident blocks. The second is a small fully associative table of addresses that recently missed in the tags. It is filled only from snoop-result feedback. Feedback comes only for forwarded snoops, and those are exactly the misses the Bloom filter could not catch. A snoop is dropped if the Bloom filter reports "absent" or the miss table holds the address. The decision appears one cycle after the snoop.

Top module: `sf_hybrid_gate`

## Requirements
- R1: While reset is high and in the cycle after it, `dec_v` and `dec_drop` are 0. Reset empties the Bloom counters and the miss table.
- R2: A snoop presented in cycle t produces `dec_v`=1 in cycle t+1. When no snoop is presented, `dec_v` is 0 in the following cycle.
- R3: Three index fields are taken from the snoop address: bits [4:0], [7:3] and [10:6]. Each selects one of 32 counters in its own bank. If any selected counter is zero, the snoop is dropped. If all are non-zero and the miss table does not hold the address, the snoop is forwarded.
- R4: A snoop to a block that is allocated and not yet evicted is never dropped.
- R5: An allocation increments the three counters selected by its address, and an eviction decrements them. Evicting every allocated block returns the addresses to the "absent" answer.
- R6: Feedback with `res_v`=1 and `res_hit`=0 records `res_a` in the miss table. A later snoop to that address is then dropped, even when the Bloom filter would forward it.
- R7: An allocation invalidates any miss-table entry holding the same address, so a later snoop to it is decided by the Bloom filter alone.
- R8: The miss table has 16 entries, filled in round-robin order from slot 0. A 17th distinct recorded miss replaces the oldest one. A miss for an address already in the table uses no slot.
- R9: A snoop whose address equals `alloc_a` of an allocation in the same cycle is forwarded.
- R10: Feedback with `res_hit`=1 records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_v | input | 1 | Snoop present |
| snp_a | input | 32 | Snoop block address |
| res_v | input | 1 | Tag-lookup result feedback valid |
| res_a | input | 32 | Block address of the reported lookup |
| res_hit | input | 1 | 1 = the lookup hit, 0 = it missed |
| alloc_v | input | 1 | Local block fill |
| alloc_a | input | 32 | Address of the filled block |
| evict_v | input | 1 | Local block eviction |
| evict_a | input | 32 | Address of the evicted block |
| dec_v | output | 1 | Decision valid, one cycle after the snoop |
| dec_drop | output | 1 | 1 = skip the tag lookup, 0 = forward it |

## Verification
The counter assertions assume that the local cache never evicts a block it did not allocate, and never holds more than 15 blocks that share one index value in any bank. The stimulus therefore tracks which pool addresses are resident. It evicts only resident ones, and it skips an allocation that would push any selected counter to 15 or beyond. Miss feedback is assumed to be truthful. The bench sets `res_hit` from its own residency record, so the miss table never receives a resident address and the never-drop-a-hit property can be checked on every snoop.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef struct packed {
    logic vld;
    logic drop;
  } sf_dec_t;
endpackage

// File: rtl/sf_incl_cbf.sv
// Counting Bloom filter: NHASH banks of counters, each indexed by an
// address slice; a bank reports presence when its selected counter is non-zero.
module sf_incl_cbf #(
  parameter int AW     = 32,
  parameter int NHASH  = 3,
  parameter int IDX_W  = 5,
  parameter int STRIDE = 3,
  parameter int CNT_W  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_v,
  input  logic [AW-1:0] inc_a,
  input  logic          dec_v,
  input  logic [AW-1:0] dec_a,
  input  logic [AW-1:0] q_a,
  output logic          q_maybe
);
  localparam int NSLOT = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [NHASH-1:0] bank_set;

  for (genvar k = 0; k < NHASH; k++) begin : g_bank
    logic [CNT_W-1:0] ctr [NSLOT];
    logic [IDX_W-1:0] ii, di, qi;

    assign ii = inc_a[k*STRIDE +: IDX_W];
    assign di = dec_a[k*STRIDE +: IDX_W];
    assign qi = q_a[k*STRIDE +: IDX_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < NSLOT; s++) ctr[s] <= '0;
      end else begin
        for (int s = 0; s < NSLOT; s++) begin
          if ((inc_v && ii == IDX_W'(s)) && !(dec_v && di == IDX_W'(s)))
            ctr[s] <= ctr[s] + ONE;
          else if ((dec_v && di == IDX_W'(s)) && !(inc_v && ii == IDX_W'(s)))
            ctr[s] <= ctr[s] - ONE;
        end
      end
    end

    assign bank_set[k] = (ctr[qi] != '0);

    // R5: a net increment must find room in the counter
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      (inc_v && !(dec_v && di == ii)) |-> (ctr[ii] != CMAX));
    // R5: a net decrement must find a non-zero counter
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
      (dec_v && !(inc_v && di == ii)) |-> (ctr[di] != '0));
  end

  assign q_maybe = &bank_set;
endmodule

// File: rtl/sf_excl_tab.sv
// Fully associative table of recent snoop-miss addresses, round-robin fill.
module sf_excl_tab #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] q_a,
  output logic          q_hit,
  input  logic          ins_v,
  input  logic [AW-1:0] ins_a,
  input  logic          kill_v,
  input  logic [AW-1:0] kill_a
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0]    tag [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    ptr;
  logic [DEPTH-1:0] m_q, m_i, m_k;
  logic             ins_do;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign m_q[i] = vld[i] && (tag[i] == q_a);
    assign m_i[i] = vld[i] && (tag[i] == ins_a);
    assign m_k[i] = vld[i] && (tag[i] == kill_a);
  end

  assign q_hit  = |m_q;
  assign ins_do = ins_v && !(|m_i) && !(kill_v && kill_a == ins_a);

  always_ff @(posedge clk) begin
    if (ins_do) tag[ptr] <= ins_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else begin
      if (ins_do) ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_do && ptr == PW'(i)) vld[i] <= 1'b1;
        else if (kill_v && m_k[i])  vld[i] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    // R7: after an allocation no valid entry holds that address
    assert_alloc_clears_R7: assert property (@(posedge clk) disable iff (rst)
      kill_v |=> !(vld[i] && tag[i] == $past(kill_a)));
  end
endmodule

// File: rtl/sf_hybrid_gate.sv
module sf_hybrid_gate
  import sf_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NHASH  = 3,
  parameter int IDX_W  = 5,
  parameter int STRIDE = 3,
  parameter int CNT_W  = 4,
  parameter int XDEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snp_v,
  input  logic [AW-1:0] snp_a,
  input  logic          res_v,
  input  logic [AW-1:0] res_a,
  input  logic          res_hit,
  input  logic          alloc_v,
  input  logic [AW-1:0] alloc_a,
  input  logic          evict_v,
  input  logic [AW-1:0] evict_a,
  output logic          dec_v,
  output logic          dec_drop
);
  logic    incl_maybe, excl_hit, same_fill;
  sf_dec_t nxt, cur;

  sf_incl_cbf #(
    .AW(AW), .NHASH(NHASH), .IDX_W(IDX_W), .STRIDE(STRIDE), .CNT_W(CNT_W)
  ) u_incl (
    .clk(clk), .rst(rst),
    .inc_v(alloc_v), .inc_a(alloc_a),
    .dec_v(evict_v), .dec_a(evict_a),
    .q_a(snp_a), .q_maybe(incl_maybe)
  );

  sf_excl_tab #(.AW(AW), .DEPTH(XDEPTH)) u_excl (
    .clk(clk), .rst(rst),
    .q_a(snp_a), .q_hit(excl_hit),
    .ins_v(res_v && !res_hit), .ins_a(res_a),
    .kill_v(alloc_v), .kill_a(alloc_a)
  );

  assign same_fill = alloc_v && (alloc_a == snp_a);

  always_comb begin
    nxt.vld  = snp_v;
    nxt.drop = snp_v && !same_fill && (!incl_maybe || excl_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign dec_v    = cur.vld;
  assign dec_drop = cur.drop;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!dec_v && !dec_drop));
  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    snp_v |=> dec_v);
  assert_no_idle_dec_R2: assert property (@(posedge clk) disable iff (rst)
    !snp_v |=> !dec_v);
  assert_fill_forwards_R9: assert property (@(posedge clk) disable iff (rst)
    (snp_v && alloc_v && alloc_a == snp_a) |=> !dec_drop);
endmodule

// File: tb/tb_sf_hybrid_gate.sv
module tb_sf_hybrid_gate;
  localparam int CLK_P = 10;
  localparam int POOL  = 20;

  logic clk = 1'b0;
  logic rst;
  logic snp_v, res_v, res_hit, alloc_v, evict_v;
  logic [31:0] snp_a, res_a, alloc_a, evict_a;
  logic dec_v, dec_drop;

  int n_run = 0, n_fail = 0;

  int          mcnt [3][32];
  logic [31:0] mtag [16];
  bit          mv   [16];
  int          mptr;

  always #(CLK_P/2) clk = ~clk;

  sf_hybrid_gate dut (
    .clk(clk), .rst(rst),
    .snp_v(snp_v), .snp_a(snp_a),
    .res_v(res_v), .res_a(res_a), .res_hit(res_hit),
    .alloc_v(alloc_v), .alloc_a(alloc_a),
    .evict_v(evict_v), .evict_a(evict_a),
    .dec_v(dec_v), .dec_drop(dec_drop)
  );

  function automatic int hx(logic [31:0] a, int k);
    return int'(a[k*3 +: 5]);
  endfunction

  function automatic bit m_maybe(logic [31:0] a);
    for (int k = 0; k < 3; k++) if (mcnt[k][hx(a, k)] == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_excl(logic [31:0] a);
    for (int i = 0; i < 16; i++) if (mv[i] && mtag[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit room(logic [31:0] a);
    for (int k = 0; k < 3; k++) if (mcnt[k][hx(a, k)] >= 14) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) for (int s = 0; s < 32; s++) mcnt[k][s] = 0;
    for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; mtag[i] = '0; end
    mptr = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    snp_v = 0; res_v = 0; res_hit = 0; alloc_v = 0; evict_v = 0;
    snp_a = '0; res_a = '0; alloc_a = '0; evict_a = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dec_v == 1'b0 && dec_drop == 1'b0, "R1 reset outputs", int'(dec_v), 0);
  endtask

  // One cycle of stimulus; dir >= 0 gives a directed expectation for dec_drop.
  task automatic cyc(bit sv, logic [31:0] sa, bit rv, logic [31:0] ra, bit rh,
                     bit av, logic [31:0] aa, bit ev, logic [31:0] ea,
                     int dir, string req);
    bit exp_f, ins;
    snp_v = sv; snp_a = sa; res_v = rv; res_a = ra; res_hit = rh;
    alloc_v = av; alloc_a = aa; evict_v = ev; evict_a = ea;
    exp_f = sv && !(av && aa == sa) && (!m_maybe(sa) || m_excl(sa));
    ins = rv && !rh && !(av && aa == ra) && !m_excl(ra);
    for (int i = 0; i < 16; i++) begin
      if (ins && i == mptr) begin mtag[i] = ra; mv[i] = 1'b1; end
      else if (av && mv[i] && mtag[i] == aa) mv[i] = 1'b0;
    end
    if (ins) mptr = (mptr + 1) % 16;
    for (int k = 0; k < 3; k++) begin
      if (av) mcnt[k][hx(aa, k)]++;
      if (ev) mcnt[k][hx(ea, k)]--;
    end
    @(negedge clk);
    if (sv) begin
      chk(dec_v == 1'b1, "R2 decision valid", int'(dec_v), 1);
      if (dir >= 0) chk(dec_drop == dir[0], req, int'(dec_drop), dir);
      else          chk(dec_drop == exp_f, req, int'(dec_drop), int'(exp_f));
    end else if (dir >= 0) begin
      chk(dec_v == 1'b0, req, int'(dec_v), 0);
    end
    snp_v = 0; res_v = 0; alloc_v = 0; evict_v = 0;
  endtask

  task automatic snoop(logic [31:0] a, int dir, string req);
    cyc(1, a, 0, '0, 0, 0, '0, 0, '0, dir, req);
  endtask
  task automatic fill(logic [31:0] a);
    cyc(0, '0, 0, '0, 0, 1, a, 0, '0, -1, "");
  endtask
  task automatic drain(logic [31:0] a);
    cyc(0, '0, 0, '0, 0, 0, '0, 1, a, -1, "");
  endtask
  task automatic report(logic [31:0] a, bit hit);
    cyc(0, '0, 1, a, hit, 0, '0, 0, '0, -1, "");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] x, s, z, pool [POOL];
    bit cached [POOL];
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    x = 32'h0000_0123;
    s = 32'h0000_0456;
    z = s ^ 32'h0010_0000;

    snoop(x, 1, "R3 empty filter drops");
    cyc(0, '0, 0, '0, 0, 0, '0, 0, '0, 0, "R2 idle gives no decision");
    fill(x);
    snoop(x, 0, "R4 resident block forwarded");
    snoop(x ^ 32'h0000_0200, 1, "R3 one bank field differs");
    drain(x);
    snoop(x, 1, "R5 evicted block absent again");
    fill(s);
    snoop(z, 0, "R3 all banks set forwards");
    report(z, 0);
    snoop(z, 1, "R6 recorded miss drops");
    report(s ^ 32'h0020_0000, 1);
    snoop(s ^ 32'h0020_0000, 0, "R10 hit feedback ignored");
    fill(z);
    drain(z);
    snoop(z, 0, "R7 fill cleared miss entry");
    report(z, 0);
    snoop(z, 1, "R6 re-recorded miss");
    cyc(1, z, 0, '0, 0, 1, z, 0, '0, 0, "R9 same-cycle fill forwards");
    drain(z);

    do_reset();
    fill(s);
    for (int i = 1; i <= 16; i++) report(s ^ (32'(i) << 24), 0);
    report(s ^ (32'd5 << 24), 0);
    report(s ^ (32'd17 << 24), 0);
    snoop(s ^ (32'd1 << 24), 0, "R8 oldest entry replaced");
    snoop(s ^ (32'd2 << 24), 1, "R8 second entry kept");
    snoop(s ^ (32'd5 << 24), 1, "R8 duplicate kept once");
    snoop(s ^ (32'd17 << 24), 1, "R8 newest entry present");
    drain(s);

    for (int i = 0; i < POOL; i++) begin
      if (i < POOL/2) pool[i] = $urandom();
      else            pool[i] = pool[i - POOL/2] ^ 32'h0040_0000;
      cached[i] = 1'b0;
    end
    for (int t = 0; t < 4000; t++) begin
      int si, ri, ai, ei;
      bit sv, rv, av, ev, must_fwd;
      si = $urandom_range(POOL-1); ri = $urandom_range(POOL-1);
      ai = $urandom_range(POOL-1); ei = $urandom_range(POOL-1);
      sv = ($urandom_range(3) != 0);
      rv = ($urandom_range(2) == 0);
      av = ($urandom_range(3) == 0) && !cached[ai] && room(pool[ai]);
      ev = ($urandom_range(4) == 0) && cached[ei] && (ei != ai);
      must_fwd = sv && (cached[si] || (av && ai == si));
      cyc(sv, pool[si], rv, pool[ri], cached[ri], av, pool[ai], ev, pool[ei],
          -1, "R3 R6 random decision");
      if (must_fwd) chk(dec_drop == 1'b0, "R4 resident never dropped", int'(dec_drop), 0);
      if (av) cached[ai] = 1'b1;
      if (ev) cached[ei] = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule